// File: doc/BRIEF.md
# Parallel ATA Host PIO Transfer Engine

This block is the host side of a parallel ATA register interface. A processor hands it commands through a small command port. Each command names a drive register, a direction, and whether it is a single access or a burst of 16-bit words. The engine then generates the address lines, the read or write strobe and the data bus. Each access follows programmable setup, strobe and hold cycle counts. The processor tracks progress through three flags: busy, transmit-ready and data-available. The most recent read word sits next to those flags.

A single access moves one word. A burst repeats the same access on the same drive register for a programmed number of words. In read bursts the words follow one another without pause. In write bursts, after each word, the engine waits for the processor to push the next data word with another command. The processor reprograms the timing counts to match the drive's PIO mode, for example setup 4, strobe 19, hold 4 for the slowest mode and setup 1, strobe 5, hold 0 for the fastest. The counts must stay stable while busy is set.

Top module: `ata_pio_host`

## Requirements
- R1: After reset, busy, transmit-ready and data-available are 0, both strobes (active low) are 1, and the data bus output enable is 0.
- R2: A write command (`cmdWrite`=1) drives `cmdAddr` on `ataAddr` and `cmdData` on `ataDataOut` with the output enable set, and pulses `ataDiowN` low. `ataDiorN` stays high.
- R3: A read command (`cmdWrite`=0) pulses `ataDiorN` low and samples `ataDataIn` in the last strobe cycle. The word then appears on `statData` and `statDav` goes to 1.
- R4: Each word takes `cfgSetup` cycles with the address valid, then the strobe low for `cfgStrobe` cycles (0 counts as 1), then `cfgHold` cycles. A single access keeps busy high for setup+strobe+hold+1 cycles. A strobe is only ever active while busy is high.
- R5: Busy rises in the cycle after the cycle in which a command is accepted, never in that same cycle.
- R6: A burst (`cmdMulti`=1) performs exactly `xferCount` word strobes on the same register. A read burst of N words keeps busy high for N*(setup+strobe+hold)+1 cycles.
- R7: When the last word completes, transmit-ready rises and busy falls one cycle later, never in the same cycle.
- R8: `xferCount`=0 in a burst means 65536 words.
- R9: In a write burst, the engine sets transmit-ready after each word and holds the bus idle until a new command supplies the next data word. Only the data of that command is used.
- R10: A command presented while busy is set and the engine is not waiting for burst data has no effect. The access in progress keeps its address, data and length, and no extra access follows.
- R11: While `cfgEnable` is 0, commands are ignored: busy stays 0, both strobes stay high and the output enable stays 0.
- R12: The two strobes are never low together. Data-available clears when a new command is accepted. Within a burst, transmit-ready clears when the next word's strobe begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgEnable | input | 1 | Interface enable; when low the bus is idle and commands are ignored |
| cfgSetup | input | 5 | Setup cycles per word |
| cfgStrobe | input | 5 | Strobe-active cycles per word (0 acts as 1) |
| cfgHold | input | 5 | Hold cycles per word |
| xferCount | input | 16 | Burst length in 16-bit words, 0 means 65536 |
| cmdValid | input | 1 | Command strobe, one cycle |
| cmdWrite | input | 1 | 1 = write to drive, 0 = read from drive |
| cmdMulti | input | 1 | 1 = burst of `xferCount` words, 0 = single word |
| cmdAddr | input | 3 | Drive register address |
| cmdData | input | 16 | Write data (also the next word during a write burst) |
| statBusy | output | 1 | Access or burst in progress |
| statTrRdy | output | 1 | A word transfer has completed |
| statDav | output | 1 | Read data available |
| statData | output | 16 | Most recently read word |
| ataAddr | output | 3 | Drive register address lines |
| ataDiorN | output | 1 | Read strobe, active low |
| ataDiowN | output | 1 | Write strobe, active low |
| ataDataOut | output | 16 | Data bus, host to drive |
| ataDataOe | output | 1 | Data bus output enable |
| ataDataIn | input | 16 | Data bus, drive to host |

## Verification
A wrong phase count or word count shows up at once as a strobe width or busy length that differs from the programmed values. The bench measures both to the cycle for every access. If the end-of-burst ordering breaks, transmit-ready is low in the last busy cycle, which shows within one cycle of the fall of busy. A bad write hand-off shows at the next falling write strobe, either as a wrong data word or as a strobe during the wait for data. A missed read capture leaves stale data on `statData` when busy falls.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_WAITD,
    ST_FIN
  } pioState_t;

  typedef struct packed {
    logic loadCmd;     // latch a new command
    logic loadData;    // latch the next write word of a burst
    logic strobeOn;    // strobe phase active
    logic capture;     // last strobe cycle: sample read data
    logic wordDone;    // a word has completed
    logic strobeEnter; // next cycle starts a strobe phase
  } ctrlStrobes_t;

endpackage

// File: rtl/ata_pio_ctrl.sv
module ata_pio_ctrl
  import ata_pio_pkg::*;
#(
  parameter int TIM_W = 5,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgEnable,
  input  logic [TIM_W-1:0] cfgSetup,
  input  logic [TIM_W-1:0] cfgStrobe,
  input  logic [TIM_W-1:0] cfgHold,
  input  logic [CNT_W-1:0] xferCount,
  input  logic             cmdValid,
  input  logic             cmdMulti,
  input  logic             isRead,
  output ctrlStrobes_t     strobes,
  output logic             busy
);

  localparam int WRD_W = CNT_W + 1;
  localparam logic [WRD_W-1:0] FULL_BURST = WRD_W'(1) << CNT_W;

  pioState_t        state, nState;
  logic [TIM_W-1:0] phaseCnt, nCnt;
  logic [WRD_W-1:0] wordsLeft, nWords;
  logic [TIM_W-1:0] strobeLast;
  logic [WRD_W-1:0] loadWords;
  logic             accept, push, endWord, enterWord;

  assign accept     = (state == ST_IDLE) && cmdValid && cfgEnable;
  assign push       = (state == ST_WAITD) && cmdValid && cfgEnable;
  assign strobeLast = (cfgStrobe == '0) ? '0 : cfgStrobe - TIM_W'(1);

  always_comb begin
    if (!cmdMulti)              loadWords = WRD_W'(1);
    else if (xferCount == '0)   loadWords = FULL_BURST;
    else                        loadWords = {1'b0, xferCount};
  end

  always_comb begin
    nState    = state;
    nCnt      = phaseCnt;
    nWords    = wordsLeft;
    endWord   = 1'b0;
    enterWord = 1'b0;
    unique case (state)
      ST_IDLE: if (accept) begin
        enterWord = 1'b1;
        nWords    = loadWords;
      end
      ST_SETUP: begin
        if (phaseCnt == '0) begin
          nState = ST_STROBE;
          nCnt   = strobeLast;
        end else nCnt = phaseCnt - TIM_W'(1);
      end
      ST_STROBE: begin
        if (phaseCnt == '0) begin
          if (cfgHold != '0) begin
            nState = ST_HOLD;
            nCnt   = cfgHold - TIM_W'(1);
          end else endWord = 1'b1;
        end else nCnt = phaseCnt - TIM_W'(1);
      end
      ST_HOLD: begin
        if (phaseCnt == '0) endWord = 1'b1;
        else nCnt = phaseCnt - TIM_W'(1);
      end
      ST_WAITD: if (push) enterWord = 1'b1;
      ST_FIN:   nState = ST_IDLE;
      default:  nState = ST_IDLE;
    endcase

    if (endWord) begin
      nWords = wordsLeft - WRD_W'(1);
      if (wordsLeft == WRD_W'(1)) nState = ST_FIN;
      else if (!isRead)           nState = ST_WAITD;
      else                        enterWord = 1'b1;
    end

    if (enterWord) begin
      if (cfgSetup != '0) begin
        nState = ST_SETUP;
        nCnt   = cfgSetup - TIM_W'(1);
      end else begin
        nState = ST_STROBE;
        nCnt   = strobeLast;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      phaseCnt  <= '0;
      wordsLeft <= '0;
    end else begin
      state     <= nState;
      phaseCnt  <= nCnt;
      wordsLeft <= nWords;
    end
  end

  always_comb begin
    strobes.loadCmd     = accept;
    strobes.loadData    = push;
    strobes.strobeOn    = (state == ST_STROBE);
    strobes.capture     = (state == ST_STROBE) && (phaseCnt == '0);
    strobes.wordDone    = endWord;
    strobes.strobeEnter = (nState == ST_STROBE) && ((state != ST_STROBE) || endWord);
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/ata_pio_dpath.sv
module ata_pio_dpath
  import ata_pio_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  ctrlStrobes_t      strobes,
  input  logic              busy,
  input  logic              cmdWrite,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [DATA_W-1:0] ataDataIn,
  output logic              isRead,
  output logic              trRdy,
  output logic              dav,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] ataAddr,
  output logic              ataDiorN,
  output logic              ataDiowN,
  output logic [DATA_W-1:0] ataDataOut,
  output logic              ataDataOe
);

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wrReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      wrReg   <= '0;
      isRead  <= 1'b0;
      rdData  <= '0;
      dav     <= 1'b0;
      trRdy   <= 1'b0;
    end else begin
      if (strobes.loadCmd) begin
        addrReg <= cmdAddr;
        isRead  <= !cmdWrite;
        wrReg   <= cmdData;
      end else if (strobes.loadData) begin
        wrReg <= cmdData;
      end

      if (strobes.capture && isRead) rdData <= ataDataIn;

      if (strobes.capture && isRead) dav <= 1'b1;
      else if (strobes.loadCmd)      dav <= 1'b0;

      if (strobes.wordDone)                               trRdy <= 1'b1;
      else if (strobes.loadCmd || strobes.strobeEnter)    trRdy <= 1'b0;
    end
  end

  assign ataAddr    = addrReg;
  assign ataDataOut = wrReg;
  assign ataDiorN   = !(cfgEnable && strobes.strobeOn && isRead);
  assign ataDiowN   = !(cfgEnable && strobes.strobeOn && !isRead);
  assign ataDataOe  = cfgEnable && busy && !isRead;

endmodule

// File: rtl/ata_pio_host.sv
module ata_pio_host
  import ata_pio_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16,
  parameter int TIM_W  = 5,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic [TIM_W-1:0]  cfgSetup,
  input  logic [TIM_W-1:0]  cfgStrobe,
  input  logic [TIM_W-1:0]  cfgHold,
  input  logic [CNT_W-1:0]  xferCount,
  input  logic              cmdValid,
  input  logic              cmdWrite,
  input  logic              cmdMulti,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  output logic              statBusy,
  output logic              statTrRdy,
  output logic              statDav,
  output logic [DATA_W-1:0] statData,
  output logic [ADDR_W-1:0] ataAddr,
  output logic              ataDiorN,
  output logic              ataDiowN,
  output logic [DATA_W-1:0] ataDataOut,
  output logic              ataDataOe,
  input  logic [DATA_W-1:0] ataDataIn
);

  ctrlStrobes_t strobes;
  logic         busy;
  logic         isRead;

  ata_pio_ctrl #(.TIM_W(TIM_W), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgEnable (cfgEnable),
    .cfgSetup  (cfgSetup),
    .cfgStrobe (cfgStrobe),
    .cfgHold   (cfgHold),
    .xferCount (xferCount),
    .cmdValid  (cmdValid),
    .cmdMulti  (cmdMulti),
    .isRead    (isRead),
    .strobes   (strobes),
    .busy      (busy)
  );

  ata_pio_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .cfgEnable  (cfgEnable),
    .strobes    (strobes),
    .busy       (busy),
    .cmdWrite   (cmdWrite),
    .cmdAddr    (cmdAddr),
    .cmdData    (cmdData),
    .ataDataIn  (ataDataIn),
    .isRead     (isRead),
    .trRdy      (statTrRdy),
    .dav        (statDav),
    .rdData     (statData),
    .ataAddr    (ataAddr),
    .ataDiorN   (ataDiorN),
    .ataDiowN   (ataDiowN),
    .ataDataOut (ataDataOut),
    .ataDataOe  (ataDataOe)
  );

  assign statBusy = busy;

endmodule

// File: rtl/ata_pio_host_chk.sv
module ata_pio_host_chk (
  input logic clk,
  input logic rstN,
  input logic cfgEnable,
  input logic cmdValid,
  input logic statBusy,
  input logic statTrRdy,
  input logic statDav,
  input logic ataDiorN,
  input logic ataDiowN,
  input logic ataDataOe
);

  // R12: strobes mutually exclusive
  p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rstN)
    (ataDiorN || ataDiowN));

  // R5: busy one cycle after acceptance
  p_busy_late_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cfgEnable && !statBusy) |=> statBusy);

  // R7: transmit-ready high in the last busy cycle
  p_rdy_before_fall_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statBusy) |-> $past(statTrRdy));

  // R11: disabled interface keeps the bus idle
  p_idle_bus_r11: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |-> (ataDiorN && ataDiowN && !ataDataOe));

  // R4: strobes only while busy
  p_strobe_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!ataDiorN || !ataDiowN) |-> statBusy);

  // R3: data-available rises only after a read strobe
  p_dav_after_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statDav) |-> $past(!ataDiorN));

endmodule

bind ata_pio_host ata_pio_host_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cfgEnable (cfgEnable),
  .cmdValid  (cmdValid),
  .statBusy  (statBusy),
  .statTrRdy (statTrRdy),
  .statDav   (statDav),
  .ataDiorN  (ataDiorN),
  .ataDiowN  (ataDiowN),
  .ataDataOe (ataDataOe)
);

// File: tb/tb_ata_pio_host.sv
module tb_ata_pio_host;

  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 180000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgEnable = 1'b0;
  logic [4:0]  cfgSetup = '0, cfgStrobe = '0, cfgHold = '0;
  logic [15:0] xferCount = '0;
  logic        cmdValid = 1'b0, cmdWrite = 1'b0, cmdMulti = 1'b0;
  logic [2:0]  cmdAddr = '0;
  logic [15:0] cmdData = '0;
  logic        statBusy, statTrRdy, statDav;
  logic [15:0] statData;
  logic [2:0]  ataAddr;
  logic        ataDiorN, ataDiowN, ataDataOe;
  logic [15:0] ataDataOut;
  logic [15:0] ataDataIn;

  int checks = 0;
  int failures = 0;

  logic [15:0] rdBase = 16'h1000;
  int          rdIdx = 0;
  int          rdPulses = 0;
  int          wrN = 0;
  logic [15:0] wrLog [8];
  logic [2:0]  wrAddrLog [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign ataDataIn = rdBase + 16'(rdIdx);

  always @(posedge ataDiorN) if (rstN) rdIdx++;
  always @(negedge ataDiorN) rdPulses++;
  always @(negedge ataDiowN) begin
    if (wrN < 8) begin
      wrLog[wrN]     = ataDataOut;
      wrAddrLog[wrN] = ataAddr;
    end
    wrN++;
  end

  ata_pio_host dut (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable),
    .cfgSetup(cfgSetup), .cfgStrobe(cfgStrobe), .cfgHold(cfgHold),
    .xferCount(xferCount), .cmdValid(cmdValid), .cmdWrite(cmdWrite),
    .cmdMulti(cmdMulti), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .statBusy(statBusy), .statTrRdy(statTrRdy), .statDav(statDav),
    .statData(statData), .ataAddr(ataAddr), .ataDiorN(ataDiorN),
    .ataDiowN(ataDiowN), .ataDataOut(ataDataOut), .ataDataOe(ataDataOe),
    .ataDataIn(ataDataIn)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setTiming(input int s, input int t, input int h);
    cfgSetup = 5'(s); cfgStrobe = 5'(t); cfgHold = 5'(h);
  endtask

  task automatic clearLogs();
    rdIdx = 0; rdPulses = 0; wrN = 0;
  endtask

  // drives one command; returns on the negedge after the accepting edge
  task automatic issue(input bit wr, input bit multi, input logic [2:0] a,
                       input logic [15:0] d, output bit busyAtCmd);
    @(negedge clk);
    cmdValid = 1'b1; cmdWrite = wr; cmdMulti = multi; cmdAddr = a; cmdData = d;
    busyAtCmd = statBusy;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitIdle(output int busyCyc, output int lowCyc, output bit lastTr,
                          output bit sawDrop);
    bit seenTr = 0;
    busyCyc = 0; lowCyc = 0; lastTr = 0; sawDrop = 0;
    while (statBusy) begin
      busyCyc++;
      if (!ataDiorN || !ataDiowN) lowCyc++;
      if (statTrRdy) seenTr = 1;
      else if (seenTr) sawDrop = 1;
      lastTr = statTrRdy;
      @(negedge clk);
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    check(statBusy == 0 && statTrRdy == 0 && statDav == 0, "R1 flags", {statBusy, statTrRdy, statDav}, 0);
    check(ataDiorN && ataDiowN && !ataDataOe, "R1 bus idle", {ataDiorN, ataDiowN, ataDataOe}, 6);
  endtask

  task automatic testSingleWrite();
    bit b0, lt, sd; int bc, lc;
    clearLogs(); setTiming(1, 5, 0);
    issue(1, 0, 3'd5, 16'hBEEF, b0);
    check(b0 == 0, "R5 busy low at command cycle", b0, 0);
    check(statBusy == 1, "R5 busy next cycle", statBusy, 1);
    check(ataDataOe == 1, "R2 output enable", ataDataOe, 1);
    waitIdle(bc, lc, lt, sd);
    check(bc == 7, "R4 single write busy length", bc, 7);
    check(lc == 5, "R4 strobe width", lc, 5);
    check(wrN == 1 && rdPulses == 0, "R2 one write strobe, no read", wrN * 10 + rdPulses, 10);
    check(wrLog[0] == 16'hBEEF, "R2 write data", wrLog[0], 16'hBEEF);
    check(wrAddrLog[0] == 3'd5, "R2 write address", wrAddrLog[0], 5);
    check(lt == 1, "R7 trRdy in last busy cycle", lt, 1);
  endtask

  task automatic testSingleRead();
    bit b0, lt, sd; int bc, lc;
    clearLogs(); rdBase = 16'h4A00; setTiming(4, 19, 4);
    issue(0, 0, 3'd7, 16'h0, b0);
    waitIdle(bc, lc, lt, sd);
    check(bc == 28, "R4 slow-mode busy length", bc, 28);
    check(lc == 19, "R4 slow-mode strobe width", lc, 19);
    check(rdPulses == 1 && wrN == 0, "R3 one read strobe", rdPulses * 10 + wrN, 10);
    check(statDav == 1, "R3 dav set", statDav, 1);
    check(statData == 16'h4A00, "R3 read data", statData, 16'h4A00);
  endtask

  task automatic testZeroPhases();
    bit b0, lt, sd; int bc, lc;
    clearLogs(); setTiming(0, 0, 0);
    issue(1, 0, 3'd1, 16'h0011, b0);
    check(statDav == 0, "R12 dav cleared by new command", statDav, 0);
    waitIdle(bc, lc, lt, sd);
    check(bc == 2, "R4 zero setup/hold, strobe 0 as 1", bc, 2);
    check(lc == 1, "R4 strobe 0 counts as 1", lc, 1);
  endtask

  task automatic testMultiRead();
    bit b0, lt, sd; int bc, lc;
    clearLogs(); rdBase = 16'h7700; setTiming(1, 2, 1); xferCount = 16'd3;
    issue(0, 1, 3'd0, 16'h0, b0);
    waitIdle(bc, lc, lt, sd);
    check(bc == 13, "R6 read burst busy length", bc, 13);
    check(rdPulses == 3, "R6 read burst strobe count", rdPulses, 3);
    check(statData == 16'h7702, "R6 last burst word", statData, 16'h7702);
    check(lt == 1, "R7 trRdy before busy falls", lt, 1);
    check(sd == 1, "R12 trRdy clears at next strobe", sd, 1);
  endtask

  task automatic testMultiWrite();
    bit b0; int issued; int stallWr; bit stallOk;
    clearLogs(); setTiming(1, 2, 1); xferCount = 16'd3;
    issue(1, 1, 3'd6, 16'hA001, b0);
    issued = 1; stallOk = 1;
    while (statBusy) begin
      if (statTrRdy && issued < 3 && wrN == issued) begin
        if (issued == 1) begin
          stallWr = wrN;
          repeat (5) begin
            @(negedge clk);
            if (wrN != stallWr || !statBusy || !ataDiowN) stallOk = 0;
          end
        end
        cmdValid = 1'b1; cmdAddr = 3'd2; cmdData = 16'hA001 + 16'(issued);
        @(negedge clk);
        cmdValid = 1'b0;
        issued++;
      end else @(negedge clk);
    end
    check(stallOk, "R9 bus waits for next data word", stallOk, 1);
    check(wrN == 3, "R6 write burst strobe count", wrN, 3);
    check(wrLog[1] == 16'hA002 && wrLog[2] == 16'hA003, "R9 pushed data used",
          {wrLog[1], wrLog[2]}, {16'hA002, 16'hA003});
    check(wrAddrLog[2] == 3'd6, "R9 address kept from first command", wrAddrLog[2], 6);
  endtask

  task automatic testBusyIgnore();
    bit b0, lt, sd; int bc, lc;
    clearLogs(); setTiming(2, 3, 2);
    issue(1, 0, 3'd4, 16'h1234, b0);
    @(negedge clk);
    cmdValid = 1'b1; cmdAddr = 3'd3; cmdData = 16'h9999; cmdWrite = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    waitIdle(bc, lc, lt, sd);
    bc += 2;
    check(bc == 8, "R10 length unchanged", bc, 8);
    repeat (4) @(negedge clk);
    check(wrN == 1 && !statBusy, "R10 no extra access", wrN, 1);
    check(wrLog[0] == 16'h1234 && wrAddrLog[0] == 3'd4, "R10 data and address kept", wrLog[0], 16'h1234);
  endtask

  task automatic testDisabled();
    bit b0, ok;
    clearLogs(); cfgEnable = 1'b0; ok = 1;
    issue(1, 0, 3'd2, 16'h5555, b0);
    repeat (4) begin
      if (statBusy || !ataDiorN || !ataDiowN || ataDataOe) ok = 0;
      @(negedge clk);
    end
    check(ok && wrN == 0, "R11 command ignored when disabled", wrN, 0);
    cfgEnable = 1'b1;
  endtask

  task automatic testFullBurst();
    bit b0, lt, sd; int bc, lc;
    clearLogs(); setTiming(0, 1, 0); xferCount = 16'd0;
    issue(0, 1, 3'd0, 16'h0, b0);
    waitIdle(bc, lc, lt, sd);
    check(bc == 65537, "R8 count 0 busy length", bc, 65537);
    check(lc == 65536, "R8 count 0 strobe cycles", lc, 65536);
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=0", WD_LIMIT);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testReset();
    cfgEnable = 1'b1;
    testSingleWrite();
    testSingleRead();
    testZeroPhases();
    testMultiRead();
    testMultiWrite();
    testBusyIgnore();
    testDisabled();
    testFullBurst();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule